// File: doc/BRIEF.md
# Parallel Flash Program Sequencer

This controller sits on the host side of an asynchronous 16-bit parallel NOR flash. The flash is built from two 8-bit chips per half, and the address space is split into a lower and an upper half, each with its own chip select. A request arrives on a valid/ready handshake and carries an operation code, an 18-bit word address and 16 bits of data. The sequencer turns each request into a series of write-enable-controlled bus cycles. Program uses four cycles. Sector erase and chip erase use six.

After the last write cycle the sequencer releases the data bus and reads the target location repeatedly. Each read looks at the polled bit, bit 7 of every byte lane. While the device's internal operation runs, that bit reads back inverted. The operation is complete when the bit matches the expected value on every lane. If that does not happen within a configurable number of clocks, the operation ends with an error.

Every pulse width and gap is a clock count. Each count is derived from a nanosecond parameter and the clock period, rounded up. The unlock addresses and command bytes are also parameters.

Top module: `pflash_cmd_seq`

## Requirements
- R1: A program request (`req_op`=0) produces exactly four write cycles, in this order:
  1. `UNLK_A1` with byte `UNLK_D1`.
  2. `UNLK_A2` with `UNLK_D2`.
  3. `UNLK_A1` with `CMD_PGM`.
  4. The request's low 17 address bits with the request data.

  In every command cycle, both byte lanes carry the same command byte.
- R2: Sector erase (`req_op`=1) and chip erase (`req_op`=2) each produce six write cycles: `UNLK_A1`/`UNLK_D1`, `UNLK_A2`/`UNLK_D2`, `UNLK_A1`/`CMD_ERS`, `UNLK_A1`/`UNLK_D1`, `UNLK_A2`/`UNLK_D2`, and a final cycle. The final cycle differs by operation:
  - Sector erase: address bits [16:14] of the request, with the lower 14 bits zero, and data `CMD_SEC`.
  - Chip erase: `UNLK_A1` with `CMD_CHP`.
- R3: The write-enable output stays low for at least ceil(`WE_LO_NS`/`CLK_NS`) clocks in each write cycle. Between two write cycles it stays high long enough that low plus high covers the write cycle time. Address and data do not change while it is low.
- R4: Request address bit 17 selects `fl_cs_n[1]` (upper half) when 1 and `fl_cs_n[0]` when 0. The two selects are never low together, and both are high while the block is idle.
- R5: Output enable is low only while write enable is high and the data bus is released. The bus is released for at least one clock before output enable falls.
- R6: Polling ends successfully when bit 7 and bit 15 of the read data equal their expected values. For program, the expected values are the programmed data's bits 7 and 15. For erase, both are 1. Success gives a one-clock `resp_valid` with `resp_err`=0, and `req_ready` returns to 1.
- R7: A read where only one byte lane matches does not end polling. Another read follows.
- R8: If polling has not succeeded within `TIMEOUT_CLKS` clocks, the block gives `resp_valid` with `resp_err`=1 and returns to idle with both chip selects high.
- R9: `req_ready` is 0 from acceptance until the response. Requests presented during that time cause no bus cycle.
- R10: After reset: `req_ready`=1, `fl_cs_n`=2'b11, `fl_we_n`=1, `fl_oe_n`=1, `fl_dq_oe`=0, and `resp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| req_addr | input | 18 | Word address; bit 17 picks the half |
| req_data | input | 16 | Data to program |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_err | output | 1 | Completion was a polling timeout |
| fl_addr | output | 17 | Flash address within a half |
| fl_dq_out | output | 16 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 16 | Data read from the flash |
| fl_cs_n | output | 2 | Active-low selects, lower and upper half |
| fl_we_n | output | 1 | Active-low write enable |
| fl_oe_n | output | 1 | Active-low output enable |

## Verification
The hardest case to reach is a read in which one byte lane has already finished while the other is still busy. A real device does this only for a short, uncontrolled moment. The bench's flash model therefore keeps a separate busy-read count for each lane. Stimulus sets the counts unequal, so only the low or only the high lane reports completion for several reads. The bench then checks that the response waits for the slower lane. The timeout path is reached in a similar way: one lane's busy count is set far beyond the reduced `TIMEOUT_CLKS` used by the bench.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_REL, S_RD, S_GAP, S_RESP
  } st_e;

  function automatic int clks(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

endpackage

// File: rtl/pflash_tick.sv
module pflash_tick #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pflash_lane_cmp.sv
module pflash_lane_cmp #(
  parameter int DW     = 16,
  parameter int LANE_W = 8
) (
  input  logic [DW-1:0] rd,
  input  logic [DW-1:0] expv,
  output logic          match
);
  localparam int LANES = DW / LANE_W;
  logic [LANES-1:0] hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = (rd[i*LANE_W + LANE_W - 1] == expv[i*LANE_W + LANE_W - 1]);
  end

  assign match = &hit;
endmodule

// File: rtl/pflash_seq_lut.sv
module pflash_seq_lut
  import pflash_pkg::*;
#(
  parameter int            CAW    = 17,
  parameter int            DW     = 16,
  parameter int            LANE_W = 8,
  parameter int            SBITS  = 3,
  parameter logic [CAW-1:0] UNLK_A1 = 17'h00555,
  parameter logic [CAW-1:0] UNLK_A2 = 17'h002AA,
  parameter logic [7:0]    UNLK_D1 = 8'hAA,
  parameter logic [7:0]    UNLK_D2 = 8'h55,
  parameter logic [7:0]    CMD_PGM = 8'hA0,
  parameter logic [7:0]    CMD_ERS = 8'h80,
  parameter logic [7:0]    CMD_SEC = 8'h30,
  parameter logic [7:0]    CMD_CHP = 8'h10
) (
  input  op_e             op,
  input  logic [2:0]      step,
  input  logic [CAW-1:0]  tgt_a,
  input  logic [DW-1:0]   tgt_d,
  output logic [CAW-1:0]  bus_a,
  output logic [DW-1:0]   bus_d,
  output logic            last
);
  localparam int LANES = DW / LANE_W;
  logic [7:0] cmd;
  logic       use_tgt;
  logic [CAW-1:0] sect_a;

  assign sect_a = {tgt_a[CAW-1 -: SBITS], {(CAW-SBITS){1'b0}}};

  always_comb begin
    cmd     = UNLK_D1;
    bus_a   = UNLK_A1;
    use_tgt = 1'b0;
    case (step)
      3'd0: begin bus_a = UNLK_A1; cmd = UNLK_D1; end
      3'd1: begin bus_a = UNLK_A2; cmd = UNLK_D2; end
      3'd2: begin bus_a = UNLK_A1; cmd = (op == OP_PROG) ? CMD_PGM : CMD_ERS; end
      3'd3: begin
        if (op == OP_PROG) begin bus_a = tgt_a; use_tgt = 1'b1; end
        else begin bus_a = UNLK_A1; cmd = UNLK_D1; end
      end
      3'd4: begin bus_a = UNLK_A2; cmd = UNLK_D2; end
      default: begin
        if (op == OP_SECT) begin bus_a = sect_a; cmd = CMD_SEC; end
        else begin bus_a = UNLK_A1; cmd = CMD_CHP; end
      end
    endcase
    bus_d = use_tgt ? tgt_d : {LANES{cmd}};
    last  = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
  end
endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pflash_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int LANE_W      = 8,
  parameter int SBITS       = 3,
  parameter int CLK_NS      = 20,
  parameter int WE_LO_NS    = 35,
  parameter int WE_HI_NS    = 20,
  parameter int WR_CYC_NS   = 70,
  parameter int OE_SETUP_NS = 10,
  parameter int OE_ACC_NS   = 35,
  parameter int OE_OFF_NS   = 20,
  parameter longint unsigned TIMEOUT_CLKS = 64'd3_000_000_000,
  parameter logic [AW-2:0] UNLK_A1 = 17'h00555,
  parameter logic [AW-2:0] UNLK_A2 = 17'h002AA,
  parameter logic [7:0]    UNLK_D1 = 8'hAA,
  parameter logic [7:0]    UNLK_D2 = 8'h55,
  parameter logic [7:0]    CMD_PGM = 8'hA0,
  parameter logic [7:0]    CMD_ERS = 8'h80,
  parameter logic [7:0]    CMD_SEC = 8'h30,
  parameter logic [7:0]    CMD_CHP = 8'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [AW-2:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic [1:0]    fl_cs_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int CAW   = AW - 1;
  localparam int T_WLO = clks(WE_LO_NS, CLK_NS);
  localparam int T_HR  = clks(WE_HI_NS, CLK_NS);
  localparam int T_CYC = clks(WR_CYC_NS, CLK_NS);
  localparam int T_WHI = (T_CYC > T_WLO + T_HR) ? (T_CYC - T_WLO) : T_HR;
  localparam int T_OS  = clks(OE_SETUP_NS, CLK_NS);
  localparam int T_REL = (T_OS > 1) ? T_OS : 1;
  localparam int T_RD  = clks(OE_ACC_NS, CLK_NS);
  localparam int T_GR  = clks(OE_OFF_NS, CLK_NS);
  localparam int T_GAP = (T_GR > 1) ? T_GR : 1;
  localparam int TW    = $clog2(T_WLO + T_WHI + T_REL + T_RD + T_GAP + 2);
  localparam int TOW   = $clog2(TIMEOUT_CLKS + 1);

  st_e            st, nxt;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q, exp_q;
  logic [2:0]     step, step_n;
  logic           ld, tz, acc, fail_q, fail_n, match, last;
  logic [TW-1:0]  ldv;
  logic [TOW-1:0] to_cnt;
  logic           to_hit;
  logic [CAW-1:0] bus_a;
  logic [DW-1:0]  bus_d;

  pflash_tick #(.W(TW)) u_tick (
    .clk(clk), .rst(rst), .load(ld), .val(ldv), .zero(tz)
  );

  pflash_seq_lut #(
    .CAW(CAW), .DW(DW), .LANE_W(LANE_W), .SBITS(SBITS),
    .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2), .UNLK_D1(UNLK_D1), .UNLK_D2(UNLK_D2),
    .CMD_PGM(CMD_PGM), .CMD_ERS(CMD_ERS), .CMD_SEC(CMD_SEC), .CMD_CHP(CMD_CHP)
  ) u_lut (
    .op(op_q), .step(step), .tgt_a(addr_q[CAW-1:0]), .tgt_d(data_q),
    .bus_a(bus_a), .bus_d(bus_d), .last(last)
  );

  pflash_lane_cmp #(.DW(DW), .LANE_W(LANE_W)) u_cmp (
    .rd(fl_dq_in), .expv(exp_q), .match(match)
  );

  assign to_hit = (to_cnt >= TOW'(TIMEOUT_CLKS - 1));

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    ldv    = '0;
    step_n = step;
    acc    = 1'b0;
    fail_n = fail_q;
    case (st)
      S_IDLE: if (req_valid) begin
        nxt = S_WLO; ld = 1'b1; ldv = TW'(T_WLO - 1); acc = 1'b1; step_n = '0;
      end
      S_WLO: if (tz) begin nxt = S_WHI; ld = 1'b1; ldv = TW'(T_WHI - 1); end
      S_WHI: if (tz) begin
        ld = 1'b1;
        if (last) begin nxt = S_REL; ldv = TW'(T_REL - 1); end
        else begin nxt = S_WLO; ldv = TW'(T_WLO - 1); step_n = step + 3'd1; end
      end
      S_REL: if (tz) begin nxt = S_RD; ld = 1'b1; ldv = TW'(T_RD); end
      S_RD: if (tz) begin
        if (match)       begin nxt = S_RESP; fail_n = 1'b0; end
        else if (to_hit) begin nxt = S_RESP; fail_n = 1'b1; end
        else begin nxt = S_GAP; ld = 1'b1; ldv = TW'(T_GAP - 1); end
      end
      S_GAP: begin
        if (to_hit)  begin nxt = S_RESP; fail_n = 1'b1; end
        else if (tz) begin nxt = S_RD; ld = 1'b1; ldv = TW'(T_RD); end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      step   <= '0;
      fail_q <= 1'b0;
      to_cnt <= '0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      exp_q  <= '0;
    end else begin
      st     <= nxt;
      step   <= step_n;
      fail_q <= fail_n;
      if (st == S_RD || st == S_GAP) to_cnt <= to_cnt + 1'b1;
      else                           to_cnt <= '0;
      if (acc) begin
        op_q   <= op_e'(req_op);
        addr_q <= req_addr;
        data_q <= req_data;
        exp_q  <= (op_e'(req_op) == OP_PROG) ? req_data : '1;
      end
    end
  end

  // Registered pins: decoded from the current state, one clock behind it.
  always_ff @(posedge clk) begin
    if (rst) begin
      fl_cs_n    <= 2'b11;
      fl_we_n    <= 1'b1;
      fl_oe_n    <= 1'b1;
      fl_dq_oe   <= 1'b0;
      fl_addr    <= '0;
      fl_dq_out  <= '0;
      req_ready  <= 1'b1;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
    end else begin
      req_ready  <= (nxt == S_IDLE);
      resp_valid <= (st == S_RESP);
      resp_err   <= (st == S_RESP) && fail_q;
      fl_we_n    <= (st != S_WLO);
      fl_oe_n    <= (st != S_RD);
      fl_dq_oe   <= (st == S_WLO) || (st == S_WHI);
      if (st == S_IDLE || st == S_RESP) fl_cs_n <= 2'b11;
      else fl_cs_n <= addr_q[AW-1] ? 2'b01 : 2'b10;
      if (st == S_WLO || st == S_WHI) begin
        fl_addr   <= bus_a;
        fl_dq_out <= bus_d;
      end else if (st != S_IDLE && st != S_RESP) begin
        fl_addr   <= addr_q[CAW-1:0];
      end
    end
  end

  // Checks next to the logic
  logic [7:0] wl_cnt;
  always_ff @(posedge clk) begin
    if (rst)           wl_cnt <= '0;
    else if (!fl_we_n) wl_cnt <= (wl_cnt == 8'hFF) ? wl_cnt : wl_cnt + 8'd1;
    else               wl_cnt <= '0;
  end

  p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (wl_cnt >= 8'(T_WLO)));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  p_cs_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (req_ready |-> fl_cs_n == 2'b11) and ($countones(~fl_cs_n) <= 1));

  p_oe_safe_r5: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (fl_we_n && !fl_dq_oe));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_oe_n) |-> $past(!fl_dq_oe));

  p_resp_idle_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (req_ready && fl_cs_n == 2'b11));

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !req_ready);
endmodule

// File: tb/pflash_cmd_seq_bench.sv
module pflash_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        resp_valid, resp_err;
  logic [16:0] fl_addr;
  logic [15:0] fl_dq_out, fl_dq_in;
  logic        fl_dq_oe, fl_we_n, fl_oe_n;
  logic [1:0]  fl_cs_n;

  always #10 clk = ~clk;

  pflash_cmd_seq #(.TIMEOUT_CLKS(64'd300)) u_pflash_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .resp_valid(resp_valid), .resp_err(resp_err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_chk = 0, n_bad = 0;
  int busy_lo = 0, busy_hi = 0, n_reads = 0;
  logic [15:0] tgt = '0;
  logic [34:0] exp_q[$];
  logic clash = 1'b0;

  // Flash model: bit 7 of a lane reads inverted while that lane is busy
  assign fl_dq_in = !fl_oe_n ?
    {tgt[15] ^ (busy_hi != 0), tgt[14:8], tgt[7] ^ (busy_lo != 0), tgt[6:0]} : 16'h0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: captures write cycles and compares against the scoreboard
  logic pwe = 1'b1, poe = 1'b1;
  logic [16:0] lat_a;
  logic [1:0]  lat_cs;
  int wl = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_oe_n && (!fl_we_n || fl_dq_oe)) clash = 1'b1;
      if (fl_cs_n == 2'b00) clash = 1'b1;
      if (pwe && !fl_we_n) begin lat_a = fl_addr; lat_cs = fl_cs_n; wl = 0; end
      if (!fl_we_n) begin
        wl++;
        if (!pwe && fl_addr != lat_a) clash = 1'b1;
      end
      if (!pwe && fl_we_n) begin
        chk(wl >= 2, "R3 write-enable low clocks", 64'(wl), 64'd2);
        if (exp_q.size() == 0)
          chk(1'b0, "R1/R2/R9 unexpected write cycle", {29'd0, lat_cs, lat_a, fl_dq_out}, 64'd0);
        else begin
          logic [34:0] e;
          e = exp_q.pop_front();
          chk({lat_cs, lat_a, fl_dq_out} == e, "R1/R2/R4 write cycle {cs,addr,data}",
              {29'd0, lat_cs, lat_a, fl_dq_out}, {29'd0, e});
        end
      end
      if (poe && !fl_oe_n) n_reads++;
      if (!poe && fl_oe_n) begin
        if (busy_lo > 0) busy_lo--;
        if (busy_hi > 0) busy_hi--;
      end
      pwe = fl_we_n;
      poe = fl_oe_n;
    end
  end

  task automatic push(input logic [1:0] cs, input logic [16:0] a, input logic [15:0] d);
    exp_q.push_back({cs, a, d});
  endtask

  task automatic do_op(input logic [1:0] op, input logic [17:0] a, input logic [15:0] d,
                       input int bl, input int bh, input bit exp_err, input bit junk,
                       input string tag);
    logic [1:0] cs;
    int to;
    cs = a[17] ? 2'b01 : 2'b10;
    push(cs, 17'h00555, 16'hAAAA);
    push(cs, 17'h002AA, 16'h5555);
    if (op == 2'd0) begin
      push(cs, 17'h00555, 16'hA0A0);
      push(cs, a[16:0], d);
      tgt = d;
    end else begin
      push(cs, 17'h00555, 16'h8080);
      push(cs, 17'h00555, 16'hAAAA);
      push(cs, 17'h002AA, 16'h5555);
      if (op == 2'd1) push(cs, {a[16:14], 14'd0}, 16'h3030);
      else            push(cs, 17'h00555, 16'h1010);
      tgt = 16'hFFFF;
    end
    busy_lo = bl; busy_hi = bh; n_reads = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R9 ready low after accept"}, 64'(req_ready), 64'd0);
    if (junk) begin
      repeat (4) @(negedge clk);
      req_op = 2'd2; req_addr = 18'h3FFFF; req_valid = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk(req_ready == 1'b0, {tag, " R9 ready stays low while busy"}, 64'(req_ready), 64'd0);
      end
      req_valid = 1'b0;
    end
    to = 0;
    while (!resp_valid && to < 5000) begin @(negedge clk); to++; end
    chk(resp_valid == 1'b1, {tag, " R6/R8 response arrives"}, 64'(resp_valid), 64'd1);
    chk(resp_err == exp_err, {tag, " R6/R8 resp_err"}, 64'(resp_err), 64'(exp_err));
    chk(fl_cs_n == 2'b11 && req_ready, {tag, " R8/R4 idle after response"},
        {61'd0, req_ready, fl_cs_n}, 64'd7);
    if (!exp_err)
      chk(n_reads == ((bl > bh) ? bl : bh) + 1, {tag, " R6/R7 polling read count"},
          64'(n_reads), 64'(((bl > bh) ? bl : bh) + 1));
    chk(exp_q.size() == 0, {tag, " R1/R2 all write cycles seen"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk);
    chk(resp_valid == 1'b0, {tag, " R6 response is one clock"}, 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({req_ready, fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe, resp_valid} == 7'b1111100,
        "R10 reset state", {57'd0, req_ready, fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe, resp_valid},
        64'h7C);
    do_op(2'd0, 18'h00123, 16'hA5C3, 2, 2, 1'b0, 1'b0, "R1 program low half");
    do_op(2'd0, 18'h30456, 16'h1234, 0, 0, 1'b0, 1'b0, "R4 program upper half");
    do_op(2'd0, 18'h00010, 16'h0080, 0, 3, 1'b0, 1'b0, "R7 high lane slower");
    do_op(2'd0, 18'h00011, 16'h8000, 4, 0, 1'b0, 1'b0, "R7 low lane slower");
    do_op(2'd1, 18'h25ABC, 16'h0000, 1, 1, 1'b0, 1'b0, "R2 sector erase");
    do_op(2'd2, 18'h00000, 16'h0000, 2, 1, 1'b0, 1'b0, "R2 chip erase");
    do_op(2'd0, 18'h00200, 16'h00FF, 0, 1000, 1'b1, 1'b0, "R8 timeout");
    do_op(2'd0, 18'h10777, 16'hBEEF, 1, 0, 1'b0, 1'b1, "R9 request while busy");
    chk(!clash, "R5/R4/R3 no bus clash, no double select, stable address", 64'(clash), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule